// File: doc/BRIEF.md
# Read-After-Write Hazard Unit for a Five-Stage Pipeline

This block decides, each cycle, where the two execute-stage operands of an in-order five-stage integer pipeline get their values, and whether the front of the pipeline must pause. It compares the source register numbers of the instruction now in execute with the destinations of the two older instructions still in flight. When one of those older instructions will write a register that the execute instruction reads, the operand is taken from that instruction's pipeline register instead of the register file. When both older instructions match, the younger one's value is used. A producer three instructions ahead needs no bypass, because the register file writes early in a cycle and reads late in it.

A load cannot supply its data until after its memory stage. When the instruction in decode reads the destination of a load that sits in execute, the unit raises a hold for fetch and decode and a flush for the decode/execute register. That flush turns the slot into a no-op for one cycle, after which the value comes through the write-back bypass. A small two-state machine (RUN, HOLD) limits each hold to a single cycle. Register 0 always reads as zero, so it never causes a bypass or a hold. Only read-after-write dependences are handled; write-after-read and write-after-write order is safe in an in-order pipeline.

States: RUN (normal issue; goes to HOLD on a load-use match) and HOLD (the cycle after a hold; always returns to RUN).

Top module: `raw_hazard_unit`

## Requirements
- R1: While rst_n is low, stall and bubble are both 0, whatever the other inputs are.
- R2: Operand A select is 2'b10 (memory-stage bypass) when the execute/memory stage has write enable set, a nonzero destination, and that destination equals ex_rs1. The value 2'b11 is never produced.
- R3: Operand A select is 2'b01 (write-back bypass) when the write-back stage has write enable set, a nonzero destination equal to ex_rs1, and R2 does not apply. Otherwise it is 2'b00 (register file).
- R4: When both the memory stage and the write-back stage match ex_rs1, operand A select is 2'b10.
- R5: A destination of register 0, or a cleared write enable, never causes a bypass or a stall.
- R6: Operand B select follows the R2 to R4 rules on ex_rs2, independently of operand A. It also serves the store data operand.
- R7: In state RUN, stall is 1 when the decode/execute register holds a load with write enable set and a nonzero destination equal to id_rs1 or id_rs2.
- R8: A non-load in decode/execute, or a match only against the older stages, causes no stall.
- R9: In the cycle after a stall cycle (state HOLD), stall is 0 whatever the inputs are. The following cycle is back in RUN.
- R10: bubble always equals stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | REG_W | First source register of the instruction in decode |
| id_rs2 | input | REG_W | Second source register of the instruction in decode |
| ex_rs1 | input | REG_W | First source register of the instruction in execute |
| ex_rs2 | input | REG_W | Second source (or store data) register of the instruction in execute |
| idex_rd | input | REG_W | Destination held in the decode/execute register |
| idex_regwr | input | 1 | Write enable held in the decode/execute register |
| idex_load | input | 1 | Load flag held in the decode/execute register |
| exmem_rd | input | REG_W | Destination held in the execute/memory register |
| exmem_regwr | input | 1 | Write enable held in the execute/memory register |
| memwb_rd | input | REG_W | Destination held in the memory/write-back register |
| memwb_regwr | input | 1 | Write enable held in the memory/write-back register |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold fetch and decode for this cycle |
| bubble | output | 1 | Clear the decode/execute control bits at the next edge |

## Verification
Operand selection is tried with no match, a match in only the memory stage, a match in only the write-back stage, and a match in both. These cases tell apart stage priority and the two select codes. Register-0 and disabled-write producers show that the validity gating is in place, and operands A and B are driven to different sources in the same vector to show that they are independent. The hold logic is tried with a load feeding either decode source, with a non-load producer, with a load whose destination is not read, and with an unchanged load-use pattern held over three cycles. That last pattern separates RUN from HOLD and shows that the hold lasts one cycle.

// File: rtl/raw_hazard_pkg.sv
package raw_hazard_pkg;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } opnd_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/raw_fwd_select.sv
module raw_fwd_select
    import raw_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output opnd_sel_e        sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
    assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

    // Younger producer (memory stage) has priority over write-back.
    always_comb begin
        if (mem_hit)     sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_REGFILE;
    end
endmodule

// File: rtl/raw_load_use.sv
module raw_load_use #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] rd_src1,
    input  logic [REG_W-1:0] rd_src2,
    input  logic [REG_W-1:0] ld_rd,
    input  logic             ld_we,
    input  logic             ld_flag,
    output logic             hazard
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic live_load;

    assign live_load = ld_flag && ld_we && (ld_rd != ZERO_REG);
    assign hazard    = live_load && ((ld_rd == rd_src1) || (ld_rd == rd_src2));
endmodule

// File: rtl/raw_hold_fsm.sv
module raw_hold_fsm
    import raw_hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic hold
);
    hold_state_e state_q;
    hold_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (hazard) state_d = ST_HOLD;
            ST_HOLD: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        hold = 1'b0;
        unique case (state_q)
            ST_RUN:  hold = rst_n && hazard;
            ST_HOLD: hold = 1'b0;
            default: hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit
    import raw_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_regwr,
    input  logic             idex_load,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_regwr,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_regwr,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             stall,
    output logic             bubble
);
    localparam int N_OPND = 2;

    logic [REG_W-1:0] ex_src [N_OPND];
    opnd_sel_e        sel    [N_OPND];
    logic             ld_hazard;
    logic             hold;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        raw_fwd_select #(.REG_W(REG_W)) sel_i (
            .src    (ex_src[g]),
            .mem_rd (exmem_rd),
            .mem_we (exmem_regwr),
            .wb_rd  (memwb_rd),
            .wb_we  (memwb_regwr),
            .sel    (sel[g])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    raw_load_use #(.REG_W(REG_W)) lu_i (
        .rd_src1 (id_rs1),
        .rd_src2 (id_rs2),
        .ld_rd   (idex_rd),
        .ld_we   (idex_regwr),
        .ld_flag (idex_load),
        .hazard  (ld_hazard)
    );

    raw_hold_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (ld_hazard),
        .hold   (hold)
    );

    assign stall  = hold;
    assign bubble = hold;
endmodule

// File: rtl/raw_hazard_chk.sv
module raw_hazard_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rs2,
    input logic [REG_W-1:0] idex_rd,
    input logic             idex_regwr,
    input logic             idex_load,
    input logic [REG_W-1:0] exmem_rd,
    input logic             exmem_regwr,
    input logic [REG_W-1:0] memwb_rd,
    input logic             memwb_regwr,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             stall,
    input logic             bubble
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!stall && !bubble); // R1
        end
    end

    AST_SEL_A_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) fwd_a != 2'b11); // R2
    AST_MEM_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_a == 2'b10) |-> (exmem_regwr && exmem_rd != '0 && exmem_rd == ex_rs1)); // R2
    AST_WB_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_a == 2'b01) |-> (memwb_regwr && memwb_rd != '0 && memwb_rd == ex_rs1 && !(exmem_regwr && exmem_rd != '0 && exmem_rd == ex_rs1))); // R3
    AST_MEM_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_b == 2'b10) |-> (exmem_regwr && exmem_rd != '0 && exmem_rd == ex_rs2)); // R6
    AST_WB_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_b == 2'b01) |-> (memwb_regwr && memwb_rd != '0 && memwb_rd == ex_rs2)); // R6
    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) stall |-> (idex_load && idex_regwr && idex_rd != '0)); // R7
    AST_ONE_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall); // R9
    AST_BUBBLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) bubble == stall); // R10
endmodule

bind raw_hazard_unit raw_hazard_chk #(.REG_W(REG_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_rs1      (ex_rs1),
    .ex_rs2      (ex_rs2),
    .idex_rd     (idex_rd),
    .idex_regwr  (idex_regwr),
    .idex_load   (idex_load),
    .exmem_rd    (exmem_rd),
    .exmem_regwr (exmem_regwr),
    .memwb_rd    (memwb_rd),
    .memwb_regwr (memwb_regwr),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .stall       (stall),
    .bubble      (bubble)
);

// File: tb/raw_hazard_unit_tb_top.sv
module raw_hazard_unit_tb_top;
    localparam int RW = 5;
    localparam int NV = 16;

    typedef struct packed {
        logic [RW-1:0] ers1;
        logic [RW-1:0] ers2;
        logic [RW-1:0] mrd;
        logic          mwe;
        logic [RW-1:0] wrd;
        logic          wwe;
        logic [RW-1:0] irs1;
        logic [RW-1:0] irs2;
        logic [RW-1:0] xrd;
        logic          xwe;
        logic          xld;
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic          es;
        logic [3:0]    req;
    } vec_t;

    // ers1 ers2 mrd mwe wrd wwe irs1 irs2 xrd xwe xld ea eb es req
    localparam vec_t VECS [NV] = '{
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8}, // R8 no match
        '{5'd2, 5'd9, 5'd2,  1'b1, 5'd4, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 4'd2}, // R2
        '{5'd2, 5'd9, 5'd3,  1'b1, 5'd2, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 4'd3}, // R3
        '{5'd2, 5'd9, 5'd2,  1'b1, 5'd2, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 4'd4}, // R4
        '{5'd0, 5'd9, 5'd0,  1'b1, 5'd0, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 reg 0
        '{5'd2, 5'd2, 5'd2,  1'b0, 5'd2, 1'b0, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 we off
        '{5'd1, 5'd8, 5'd8,  1'b1, 5'd4, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b00, 2'b10, 1'b0, 4'd6}, // R6
        '{5'd3, 5'd8, 5'd3,  1'b1, 5'd8, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b10, 2'b01, 1'b0, 4'd6}, // R6
        '{5'd4, 5'd4, 5'd4,  1'b1, 5'd9, 1'b1, 5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 2'b10, 2'b10, 1'b0, 4'd6}, // R6
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd10, 5'd6,  5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd7}, // R7 rs1
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd6,  5'd10, 5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd7}, // R7 rs2
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd10, 5'd6,  5'd10, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8}, // R8 non-load
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd0,  5'd6,  5'd0,  1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 load to r0
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd10, 5'd6,  5'd10, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 load we off
        '{5'd1, 5'd2, 5'd3,  1'b1, 5'd4, 1'b1, 5'd11, 5'd12, 5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8}, // R8 unread dest
        '{5'd1, 5'd2, 5'd10, 1'b1, 5'd4, 1'b1, 5'd10, 5'd6,  5'd7,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8}  // R8 older stage only
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [RW-1:0] idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
    logic          idex_regwr = 1'b0, idex_load = 1'b0, exmem_regwr = 1'b0, memwb_regwr = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raw_hazard_unit #(.REG_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .idex_rd(idex_rd), .idex_regwr(idex_regwr), .idex_load(idex_load),
        .exmem_rd(exmem_rd), .exmem_regwr(exmem_regwr),
        .memwb_rd(memwb_rd), .memwb_regwr(memwb_regwr),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
    );

    function automatic string req_tag(input logic [3:0] n);
        case (n)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ex_rs1 = v.ers1;  ex_rs2 = v.ers2;
        exmem_rd = v.mrd; exmem_regwr = v.mwe;
        memwb_rd = v.wrd; memwb_regwr = v.wwe;
        id_rs1 = v.irs1;  id_rs2 = v.irs2;
        idex_rd = v.xrd;  idex_regwr = v.xwe; idex_load = v.xld;
    endtask

    initial begin
        // R1: reset holds stall low even under a load-use pattern
        drive(VECS[9]);
        @(negedge clk); #1;
        check(stall == 1'b0, "R1 stall in reset", int'(stall), 0);
        check(bubble == 1'b0, "R1 bubble in reset", int'(bubble), 0);
        drive('0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check(fwd_a == VECS[i].ea, $sformatf("%s fwd_a vec %0d", req_tag(VECS[i].req), i), int'(fwd_a), int'(VECS[i].ea));
            check(fwd_b == VECS[i].eb, $sformatf("%s fwd_b vec %0d", req_tag(VECS[i].req), i), int'(fwd_b), int'(VECS[i].eb));
            check(stall == VECS[i].es, $sformatf("%s stall vec %0d", req_tag(VECS[i].req), i), int'(stall), int'(VECS[i].es));
            check(bubble == stall, $sformatf("R10 bubble vec %0d", i), int'(bubble), int'(stall));
            @(negedge clk);
            drive('0);
            @(negedge clk);
        end

        // R9: a held load-use pattern stalls, skips one cycle, stalls again
        @(negedge clk);
        drive(VECS[9]);
        #1;
        check(stall == 1'b1, "R9 first cycle", int'(stall), 1);
        @(negedge clk); #1;
        check(stall == 1'b0, "R9 hold cycle", int'(stall), 0);
        check(bubble == 1'b0, "R10 hold cycle bubble", int'(bubble), 0);
        @(negedge clk); #1;
        check(stall == 1'b1, "R9 back in run", int'(stall), 1);
        drive('0);
        @(negedge clk); @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule